// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block sits between a serial deserializer and the register port of a 16550-style UART receiver. It takes completed bytes and break events from the deserializer and stores them, either in a 16-entry first-in first-out queue or, with the queue switched off, in a single holding byte. It serves three kinds of register access. A receive-data read pops the oldest byte. A FIFO-control write selects the mode, flushes the queue and sets the trigger level. A line-status read clears the sticky error flags.

The block drives five indications: data ready, overrun, break seen, trigger reached and character timeout pending. The timeout is handled by a three-state machine. TMO_IDLE means no timing is in progress. TMO_ARMED means the block is counting 1x bit-rate ticks while bytes wait. TMO_FIRED means the timeout is pending. The transitions are:

- arm: TMO_IDLE to TMO_ARMED, on a receive event or data read that leaves bytes queued.
- restart: TMO_ARMED to TMO_ARMED, which zeroes the count.
- drain: TMO_ARMED to TMO_IDLE, when a read empties the queue.
- expire: TMO_ARMED to TMO_FIRED, when the count reaches four frame times.
- acknowledge: TMO_FIRED to TMO_ARMED or TMO_IDLE, on a data read.
- cancel: any state to TMO_IDLE, on a queue flush or while the queue is off.

The frame length in bits comes from the line-control byte supplied on an input.

Top module: `uart_rx_fifo`

## Requirements
- R1: With the queue on, up to DEPTH bytes are held and returned oldest first on `rd_data`; `fill_level` gives the number held.
- R2: With the queue on and full, an arriving byte that is not matched by a read in the same cycle is discarded, `overrun` is set and the stored bytes are unchanged.
- R3: `fcr_wdata[7:6]` selects the trigger level: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. With the queue on, `trig_hit` is high when data is ready and `fill_level` is at least the level. With the queue off, `trig_hit` equals `data_ready`.
- R4: A `rx_break` event stores a 0x00 byte and sets both `brk_seen` and `data_ready`.
- R5: A `lsr_rd` pulse clears `brk_seen` and `overrun`, unless a new event sets them in the same cycle.
- R6: With the queue on and bytes held, `timeout_pend` rises on the tick that completes 4 x frame-bits ticks with no receive event and no data read in between. A receive event restarts the count. A data read clears `timeout_pend` and restarts the count if bytes remain.
- R7: Frame bits are 1 start bit, plus 1 if `lcr_cfg[3]` is set, plus `lcr_cfg[1:0]`+5 data bits, plus 2 stop bits if `lcr_cfg[2]` is set or 1 if it is clear. This gives timeout lengths of 40 ticks for 0x03, 48 for 0x0F and 28 for 0x00.
- R8: An `fcr_wr` with `fcr_wdata[0]` sets the queue on or off. `fcr_wdata[1]` requests a receive flush, and any change of bit 0 forces one. A flush empties the queue, clears `data_ready` and `brk_seen`, and cancels the timeout.
- R9: A data read of an empty queue returns 0x00. `data_ready` clears when the count reaches zero.
- R10: With the queue off, each byte replaces the holding byte. A byte arriving while `data_ready` is set, with no read in that cycle, sets `overrun`. A data read clears `data_ready` and `brk_seen`.
- R11: A receive and a data read in the same cycle are both honoured, including when the queue is full; the level then stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Deserializer delivers a byte this cycle |
| rx_data | input | DW | Delivered byte |
| rx_break | input | 1 | Deserializer reports a break this cycle |
| baud_tick | input | 1 | 1x bit-rate tick |
| lcr_cfg | input | 8 | Line-control byte (frame format) |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_wdata | input | 8 | FIFO-control write value |
| rbr_rd | input | 1 | Receive-data read strobe |
| lsr_rd | input | 1 | Line-status read strobe |
| rd_data | output | DW | Byte returned by a receive-data read |
| fill_level | output | $clog2(DEPTH+1) | Bytes held in the queue |
| data_ready | output | 1 | Data available |
| overrun | output | 1 | Byte lost flag |
| brk_seen | output | 1 | Break received flag |
| trig_hit | output | 1 | Trigger level reached |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The bench builds the block with DEPTH=16 and DW=8. With these values the 14-byte trigger and the full-queue overrun are both within reach in a few dozen cycles, and a simultaneous read and write on a full queue can be exercised directly. Three line-control settings give timeout lengths of 28, 40 and 48 ticks. At each length the bench probes the tick just before expiry and the expiring tick, so an off-by-one in the frame arithmetic or the counter shows up at the ports.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_ARMED = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;

    // Bits per character: start + optional parity + data + stop
    function automatic logic [3:0] frame_bits(input logic [7:0] lcr);
        logic [3:0] n;
        n = 4'd1 + {3'd0, lcr[3]} + ({2'd0, lcr[1:0]} + 4'd5);
        n = n + (lcr[2] ? 4'd2 : 4'd1);
        return n;
    endfunction

    // Trigger level in bytes for a two-bit code
    function automatic logic [4:0] trig_bytes(input logic [1:0] code);
        logic [4:0] v;
        unique case (code)
            2'b00:   v = 5'd1;
            2'b01:   v = 5'd4;
            2'b10:   v = 5'd8;
            default: v = 5'd14;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import uart_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       kill,
    input  logic       restart,
    input  logic       rd_clear,
    input  logic       has_data,
    input  logic       tick,
    input  logic [5:0] limit,
    output logic       pending
);
    tmo_state_e st_q, st_d;
    logic [5:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (kill || !enable) begin
            st_d  = TMO_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                TMO_IDLE: begin
                    if (restart && has_data) begin
                        st_d  = TMO_ARMED;
                        cnt_d = '0;
                    end
                end
                TMO_ARMED: begin
                    if (restart) begin
                        st_d  = has_data ? TMO_ARMED : TMO_IDLE;
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q == limit - 6'd1) begin
                            st_d  = TMO_FIRED;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 6'd1;
                        end
                    end
                end
                TMO_FIRED: begin
                    if (rd_clear) begin
                        st_d  = has_data ? TMO_ARMED : TMO_IDLE;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = TMO_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TMO_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        pending = (st_q == TMO_FIRED);
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [DW-1:0]              rx_data,
    input  logic                       rx_break,
    input  logic                       baud_tick,
    input  logic [7:0]                 lcr_cfg,
    input  logic                       fcr_wr,
    input  logic [7:0]                 fcr_wdata,
    input  logic                       rbr_rd,
    input  logic                       lsr_rd,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic                       data_ready,
    output logic                       overrun,
    output logic                       brk_seen,
    output logic                       trig_hit,
    output logic                       timeout_pend
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic          fifo_on_q;
    logic [1:0]    trig_code_q;
    logic          dr_q, brk_q, ovr_q;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] head;
    logic [CW-1:0] count, count_next;
    logic          ev, flush, push, pop, drop, nf_ovr;
    logic [DW-1:0] ev_byte;
    logic [5:0]    tmo_limit;

    assign ev      = rx_valid | rx_break;
    assign ev_byte = rx_break ? '0 : rx_data;
    assign flush   = fcr_wr && (fcr_wdata[1] || (fcr_wdata[0] != fifo_on_q));
    assign pop     = rbr_rd && fifo_on_q && (count != '0) && !flush;
    assign push    = ev && fifo_on_q && !flush && ((count != FULL) || pop);
    assign drop    = ev && fifo_on_q && !flush && (count == FULL) && !pop;
    assign nf_ovr  = ev && !fifo_on_q && !flush && dr_q && !rbr_rd;

    always_comb begin
        if (flush) count_next = '0;
        else       count_next = count + CW'(push) - CW'(pop);
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .pop   (pop),
        .wdata (ev_byte),
        .head  (head),
        .count (count)
    );

    assign tmo_limit = {frame_bits(lcr_cfg), 2'b00};

    rxq_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (fifo_on_q),
        .kill     (flush),
        .restart  ((ev || rbr_rd) && fifo_on_q),
        .rd_clear (rbr_rd),
        .has_data (count_next != '0),
        .tick     (baud_tick),
        .limit    (tmo_limit),
        .pending  (timeout_pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_on_q   <= 1'b0;
            trig_code_q <= 2'b00;
            dr_q        <= 1'b0;
            brk_q       <= 1'b0;
            ovr_q       <= 1'b0;
            hold_q      <= '0;
        end else begin
            if (fcr_wr) begin
                fifo_on_q   <= fcr_wdata[0];
                trig_code_q <= fcr_wdata[7:6];
            end
            // data ready
            if (flush)           dr_q <= 1'b0;
            else if (fifo_on_q)  dr_q <= (count_next != '0);
            else if (ev)         dr_q <= 1'b1;
            else if (rbr_rd)     dr_q <= 1'b0;
            // break flag
            if (flush)           brk_q <= 1'b0;
            else if (rx_break)   brk_q <= 1'b1;
            else if (lsr_rd)     brk_q <= 1'b0;
            else if (rbr_rd && (!fifo_on_q || count_next == '0)) brk_q <= 1'b0;
            // overrun flag
            if (drop || nf_ovr)  ovr_q <= 1'b1;
            else if (lsr_rd)     ovr_q <= 1'b0;
            // holding byte for queue-off mode
            if (ev && !fifo_on_q && !flush) hold_q <= ev_byte;
        end
    end

    assign rd_data    = fifo_on_q ? ((count == '0) ? '0 : head) : hold_q;
    assign fill_level = count;
    assign data_ready = dr_q;
    assign overrun    = ovr_q;
    assign brk_seen   = brk_q;
    assign trig_hit   = dr_q && (!fifo_on_q || (count >= CW'(trig_bytes(trig_code_q))));
endmodule

// File: rtl/rxq_checks.sv
module rxq_checks #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_on,
    input logic                       rx_valid,
    input logic                       rx_break,
    input logic                       fcr_wr,
    input logic                       rbr_rd,
    input logic                       lsr_rd,
    input logic [$clog2(DEPTH+1)-1:0] fill_level,
    input logic                       data_ready,
    input logic                       overrun,
    input logic                       brk_seen,
    input logic                       timeout_pend
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL);

    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && fill_level == FULL && rx_valid && !rbr_rd && !fcr_wr
        |=> overrun && fill_level == FULL);

    p_break_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break && !fcr_wr |=> brk_seen && data_ready);

    p_lsr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !rx_valid && !rx_break |=> !overrun && !brk_seen);

    p_pend_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pend |-> fill_level != '0);

    p_read_acks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && rbr_rd |=> !timeout_pend);

    p_empty_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && fill_level == '0 |-> !data_ready);

    p_hold_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on && data_ready && rx_valid && !rbr_rd && !fcr_wr |=> overrun);
endmodule

bind uart_rx_fifo rxq_checks #(.DEPTH(DEPTH)) u_rxq_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_on      (fifo_on_q),
    .rx_valid     (rx_valid),
    .rx_break     (rx_break),
    .fcr_wr       (fcr_wr),
    .rbr_rd       (rbr_rd),
    .lsr_rd       (lsr_rd),
    .fill_level   (fill_level),
    .data_ready   (data_ready),
    .overrun      (overrun),
    .brk_seen     (brk_seen),
    .timeout_pend (timeout_pend)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH+1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_break = 1'b0;
    logic          baud_tick = 1'b0;
    logic [7:0]    lcr_cfg = 8'h03;
    logic          fcr_wr = 1'b0;
    logic [7:0]    fcr_wdata = '0;
    logic          rbr_rd = 1'b0;
    logic          lsr_rd = 1'b0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] fill_level;
    logic          data_ready, overrun, brk_seen, trig_hit, timeout_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .baud_tick(baud_tick), .lcr_cfg(lcr_cfg),
        .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
        .rd_data(rd_data), .fill_level(fill_level), .data_ready(data_ready),
        .overrun(overrun), .brk_seen(brk_seen), .trig_hit(trig_hit),
        .timeout_pend(timeout_pend)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic push_break();
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
    endtask

    task automatic read_rbr(output logic [7:0] v);
        @(negedge clk); v = rd_data; rbr_rd = 1'b1;
        @(negedge clk); rbr_rd = 1'b0;
    endtask

    task automatic read_lsr();
        @(negedge clk); lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;
    endtask

    task automatic write_fcr(input logic [7:0] v);
        @(negedge clk); fcr_wr = 1'b1; fcr_wdata = v;
        @(negedge clk); fcr_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); baud_tick = 1'b1;
            @(negedge clk); baud_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1", "reset level", fill_level, 0);
        chk("R9", "reset ready", data_ready, 0);
        chk("R5", "reset overrun", overrun, 0);
        chk("R4", "reset break", brk_seen, 0);
        chk("R6", "reset timeout", timeout_pend, 0);
        chk("R3", "reset trigger", trig_hit, 0);
    endtask

    task automatic t_order();
        logic [7:0] v;
        write_fcr(8'h01);
        push_byte(8'hA1); push_byte(8'hA2); push_byte(8'hA3);
        chk("R1", "level after 3", fill_level, 3);
        chk("R1", "ready", data_ready, 1);
        read_rbr(v); chk("R1", "first", v, 8'hA1);
        read_rbr(v); chk("R1", "second", v, 8'hA2);
        chk("R9", "ready with one left", data_ready, 1);
        read_rbr(v); chk("R1", "third", v, 8'hA3);
        chk("R9", "ready cleared at zero", data_ready, 0);
        read_rbr(v); chk("R9", "empty read", v, 8'h00);
        chk("R9", "level stays zero", fill_level, 0);
    endtask

    task automatic t_trigger();
        int lvl [4] = '{1, 4, 8, 14};
        for (int c = 0; c < 4; c++) begin
            write_fcr({c[1:0], 6'b000011});
            for (int k = 0; k < lvl[c] - 1; k++) push_byte(8'(k));
            chk("R3", $sformatf("below level code %0d", c), trig_hit, 0);
            push_byte(8'h5A);
            chk("R3", $sformatf("at level code %0d", c), trig_hit, 1);
        end
        write_fcr(8'h03);
    endtask

    task automatic t_full();
        logic [7:0] v;
        write_fcr(8'h03);
        for (int i = 0; i < DEPTH; i++) push_byte(8'h10 + 8'(i));
        chk("R2", "no overrun when just full", overrun, 0);
        push_byte(8'hAA);
        chk("R2", "overrun on full", overrun, 1);
        chk("R2", "level held", fill_level, DEPTH);
        read_lsr();
        chk("R5", "lsr clears overrun", overrun, 0);
        @(negedge clk); v = rd_data; rx_valid = 1'b1; rx_data = 8'hBB; rbr_rd = 1'b1;
        @(negedge clk); rx_valid = 1'b0; rbr_rd = 1'b0;
        chk("R11", "pop value at full", v, 8'h10);
        chk("R11", "level after push+pop", fill_level, DEPTH);
        chk("R11", "no overrun on push+pop", overrun, 0);
        for (int i = 1; i < DEPTH; i++) begin
            read_rbr(v); chk("R2", "kept content", v, 8'h10 + 8'(i));
        end
        read_rbr(v); chk("R11", "byte from push+pop", v, 8'hBB);
        chk("R9", "drained", data_ready, 0);
    endtask

    task automatic t_break();
        logic [7:0] v;
        write_fcr(8'h03);
        push_break();
        chk("R4", "break flag", brk_seen, 1);
        chk("R4", "ready on break", data_ready, 1);
        chk("R4", "break stored", fill_level, 1);
        push_byte(8'h77);
        read_lsr();
        chk("R5", "lsr clears break", brk_seen, 0);
        read_rbr(v); chk("R4", "zero byte", v, 8'h00);
        read_rbr(v); chk("R4", "following byte", v, 8'h77);
    endtask

    task automatic t_timeout();
        logic [7:0] cfg [3] = '{8'h03, 8'h0F, 8'h00};
        int         lim [3] = '{40, 48, 28};
        logic [7:0] v;
        for (int c = 0; c < 3; c++) begin
            lcr_cfg = cfg[c];
            write_fcr(8'h03);
            push_byte(8'h31);
            ticks(lim[c] - 1);
            chk("R7", $sformatf("no fire before %0d", lim[c]), timeout_pend, 0);
            push_byte(8'h32);
            ticks(lim[c] - 1);
            chk("R6", "receive restarts count", timeout_pend, 0);
            ticks(1);
            chk("R7", $sformatf("fires at %0d", lim[c]), timeout_pend, 1);
            read_rbr(v);
            chk("R6", "read clears pending", timeout_pend, 0);
            ticks(lim[c] - 1);
            chk("R6", "rearmed not yet", timeout_pend, 0);
            ticks(1);
            chk("R6", "rearmed fires", timeout_pend, 1);
            read_rbr(v);
            chk("R6", "cleared when empty", timeout_pend, 0);
            ticks(lim[c] + 2);
            chk("R6", "no fire while empty", timeout_pend, 0);
        end
        lcr_cfg = 8'h03;
    endtask

    task automatic t_fcr();
        write_fcr(8'h03);
        push_byte(8'h01); push_byte(8'h02); push_byte(8'h03);
        chk("R8", "filled", fill_level, 3);
        write_fcr(8'h03);
        chk("R8", "flush empties", fill_level, 0);
        chk("R8", "flush clears ready", data_ready, 0);
        push_byte(8'h44);
        ticks(39);
        write_fcr(8'h03);
        ticks(45);
        chk("R8", "flush cancels timeout", timeout_pend, 0);
        push_break();
        chk("R8", "break before mode change", brk_seen, 1);
        write_fcr(8'h00);
        chk("R8", "mode change clears break", brk_seen, 0);
        chk("R8", "mode change clears ready", data_ready, 0);
        chk("R8", "mode change empties", fill_level, 0);
    endtask

    task automatic t_nonfifo();
        logic [7:0] v;
        push_byte(8'h55);
        chk("R10", "ready", data_ready, 1);
        chk("R3", "trigger follows ready", trig_hit, 1);
        chk("R10", "holding byte", rd_data, 8'h55);
        push_byte(8'h66);
        chk("R10", "overrun on second", overrun, 1);
        chk("R10", "queue unused", fill_level, 0);
        ticks(60);
        chk("R6", "no timeout with queue off", timeout_pend, 0);
        read_rbr(v);
        chk("R10", "newest byte", v, 8'h66);
        chk("R10", "read clears ready", data_ready, 0);
        read_lsr();
        chk("R5", "lsr clears overrun", overrun, 0);
        push_break();
        chk("R10", "break flag", brk_seen, 1);
        read_rbr(v);
        chk("R10", "break byte", v, 8'h00);
        chk("R10", "read clears break", brk_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_trigger();
        t_full();
        t_break();
        t_timeout();
        t_fcr();
        t_nonfifo();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule